// File: doc/BRIEF.md
# Aged-Leg Preselecting Switch Selector

This block picks the switching state of a two-level three-phase inverter for one control sample. It receives three predicted reference voltages and the index of the leg that has aged the most. It then chooses the state that comes closest to the references. To spare the aged leg, the block first works out where that leg's reference ranks among the three. If it is the highest, the aged leg's upper switch is held on. If it is the lowest, the leg's lower switch is held on. In either case only the four states that respect that hold are weighed. When the aged leg's reference is the middle one, all eight states are weighed.

Holding the aged leg in this way gives it clamped stretches of up to 120 electrical degrees against each rail. During those stretches the leg does not commute, so its switching loss and thermal stress drop. The block examines one candidate per clock. A clamped sample therefore resolves in four cycles and an unclamped one in eight. The result is a registered 3-bit state together with a one-cycle done strobe.

Top module: `leg_relief_selector`

## Requirements
- R1: While reset is asserted and after it is released, `done` is 0 and `sw_state` is 3'b000 until the first result.
- R2: `sw_state` bit 2 is leg a, bit 1 is leg b and bit 0 is leg c. A 1 means the upper switch is on, which gives a phase voltage of `V_HI`. A 0 means the lower switch is on, which gives `V_LO`. `aged_leg` is 0 for a, 1 for b and 2 for c.
- R3: When the aged leg's reference ranks highest, only the four states with that leg's bit set to 1 are candidates, and the result has that bit set to 1.
- R4: When the aged leg's reference ranks lowest, only the four states with that leg's bit set to 0 are candidates, and the result has that bit set to 0.
- R5: When the aged leg's reference ranks in the middle, or when `aged_leg` is 3, all eight states are candidates.
- R6: The cost of a candidate is the sum, over the three legs, of |reference − phase voltage of the candidate|. The candidate with the least cost wins.
- R7: Equal references are ranked by treating the lower leg index as the larger value. With all three references equal, leg a is highest, leg c is lowest and leg b is in the middle.
- R8: State indices map as 0=000, 1=100, 2=110, 3=010, 4=011, 5=001, 6=101, 7=111. Candidates are weighed in ascending index order, and a tie in cost goes to the lower index.
- R9: `done` is a one-cycle pulse. For a clamped sample it is high after the 4th rising edge following the edge that accepts `start`. For an unclamped sample it is high after the 8th such edge.
- R10: A `start` that arrives while a sample is being evaluated is ignored. It changes neither the result nor its timing.
- R11: `sw_state` holds its value between results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a sample; accepted when idle |
| ref_a | input | REF_W | Predicted reference, leg a (signed) |
| ref_b | input | REF_W | Predicted reference, leg b (signed) |
| ref_c | input | REF_W | Predicted reference, leg c (signed) |
| aged_leg | input | 2 | Index of the aged leg (0..2; 3 = none) |
| sw_state | output | 3 | Selected switching state |
| done | output | 1 | One-cycle strobe when `sw_state` is updated |

## Verification
The bench builds the block with its default values: a 12-bit reference width and phase voltages of +1000 and −1000. These values let references be placed near, above and below both rails. They make it possible to construct cases where the preselection overrides the state that cost alone would choose, such as a negative highest reference that is still forced high. With all references at zero, every candidate costs the same, which exposes the tie-break by index. Equal references, in turn, expose the rank tie-break on each leg.

// File: rtl/leg_relief_pkg.sv
package leg_relief_pkg;

  localparam int unsigned NUM_LEGS   = 3;
  localparam int unsigned NUM_STATES = 1 << NUM_LEGS;
  localparam int unsigned IDX_W      = $clog2(NUM_STATES);

  // state index -> leg bits {a,b,c}
  function automatic logic [NUM_LEGS-1:0] idx2bits(input logic [IDX_W-1:0] idx);
    logic [NUM_LEGS-1:0] b;
    case (idx)
      3'd0:    b = 3'b000;
      3'd1:    b = 3'b100;
      3'd2:    b = 3'b110;
      3'd3:    b = 3'b010;
      3'd4:    b = 3'b011;
      3'd5:    b = 3'b001;
      3'd6:    b = 3'b101;
      default: b = 3'b111;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/leg_rank.sv
module leg_rank #(
  parameter int unsigned REF_W = 12
) (
  input  logic signed [REF_W-1:0] ref_a,
  input  logic signed [REF_W-1:0] ref_b,
  input  logic signed [REF_W-1:0] ref_c,
  input  logic        [1:0]       leg,
  output logic                    is_top,
  output logic                    is_bot
);
  logic a_top, b_top, c_top, a_bot, b_bot, c_bot;

  // lower index counts as larger on equality
  always_comb begin
    a_top = (ref_a >= ref_b) && (ref_a >= ref_c);
    b_top = (ref_b >  ref_a) && (ref_b >= ref_c);
    c_top = (ref_c >  ref_a) && (ref_c >  ref_b);
    a_bot = (ref_a <  ref_b) && (ref_a <  ref_c);
    b_bot = (ref_b <= ref_a) && (ref_b <  ref_c);
    c_bot = (ref_c <= ref_a) && (ref_c <= ref_b);
    case (leg)
      2'd0:    begin is_top = a_top; is_bot = a_bot; end
      2'd1:    begin is_top = b_top; is_bot = b_bot; end
      2'd2:    begin is_top = c_top; is_bot = c_bot; end
      default: begin is_top = 1'b0;  is_bot = 1'b0;  end
    endcase
  end
endmodule

// File: rtl/cand_pick.sv
module cand_pick
  import leg_relief_pkg::*;
(
  input  logic             clamp_hi,
  input  logic             clamp_lo,
  input  logic [1:0]       leg,
  input  logic [IDX_W-1:0] pick,
  output logic [IDX_W-1:0] cand_idx
);
  logic [IDX_W:0]      seen;
  logic [NUM_LEGS-1:0] bits;
  logic                leg_bit;
  logic                qual;

  // k-th qualifying state in ascending index order
  always_comb begin
    seen     = '0;
    cand_idx = '0;
    bits     = '0;
    leg_bit  = 1'b0;
    qual     = 1'b0;
    for (int i = 0; i < NUM_STATES; i++) begin
      bits = idx2bits(IDX_W'(i));
      case (leg)
        2'd0:    leg_bit = bits[2];
        2'd1:    leg_bit = bits[1];
        default: leg_bit = bits[0];
      endcase
      qual = !(clamp_hi || clamp_lo) || (leg_bit == clamp_hi);
      if (qual) begin
        if (seen == {1'b0, pick}) cand_idx = IDX_W'(i);
        seen = seen + 1'b1;
      end
    end
  end
endmodule

// File: rtl/state_cost.sv
module state_cost #(
  parameter int unsigned REF_W  = 12,
  parameter int          V_HI   = 1000,
  parameter int          V_LO   = -1000,
  localparam int unsigned COST_W = REF_W + 3
) (
  input  logic signed [REF_W-1:0]  ref_a,
  input  logic signed [REF_W-1:0]  ref_b,
  input  logic signed [REF_W-1:0]  ref_c,
  input  logic        [2:0]        bits,
  output logic        [COST_W-1:0] cost
);
  localparam logic signed [COST_W-1:0] VH = COST_W'(V_HI);
  localparam logic signed [COST_W-1:0] VL = COST_W'(V_LO);

  function automatic logic [COST_W-1:0] absdiff(input logic signed [REF_W-1:0] r,
                                                 input logic on);
    logic signed [COST_W-1:0] d;
    d = COST_W'(r) - (on ? VH : VL);
    return d[COST_W-1] ? COST_W'(-d) : COST_W'(d);
  endfunction

  always_comb begin
    cost = absdiff(ref_a, bits[2]) + absdiff(ref_b, bits[1]) + absdiff(ref_c, bits[0]);
  end
endmodule

// File: rtl/leg_relief_selector.sv
module leg_relief_selector
  import leg_relief_pkg::*;
#(
  parameter int unsigned REF_W = 12,
  parameter int          V_HI  = 1000,
  parameter int          V_LO  = -1000,
  localparam int unsigned COST_W = REF_W + 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic signed [REF_W-1:0] ref_a,
  input  logic signed [REF_W-1:0] ref_b,
  input  logic signed [REF_W-1:0] ref_c,
  input  logic [1:0]             aged_leg,
  output logic [2:0]             sw_state,
  output logic                   done
);
  localparam logic [IDX_W-1:0] LAST_CLAMP = IDX_W'(NUM_STATES/2 - 1);
  localparam logic [IDX_W-1:0] LAST_FULL  = IDX_W'(NUM_STATES - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  // registers
  logic signed [REF_W-1:0] ra_q, rb_q, rc_q;
  logic [1:0]              leg_q;
  logic                    hi_q, lo_q, busy_q, done_q;
  logic [IDX_W-1:0]        cnt_q, best_q;
  logic [COST_W-1:0]       bcost_q;
  logic [2:0]              st_q;

  // next-state
  logic signed [REF_W-1:0] ra_d, rb_d, rc_d;
  logic [1:0]              leg_d;
  logic                    hi_d, lo_d, busy_d, done_d;
  logic [IDX_W-1:0]        cnt_d, best_d;
  logic [COST_W-1:0]       bcost_d;
  logic [2:0]              st_d;

  logic              rk_top, rk_bot, accept, take, last;
  logic [IDX_W-1:0]  cand, win;
  logic [COST_W-1:0] ccost;

  leg_rank #(.REF_W(REF_W)) u_rank (
    .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c), .leg(aged_leg),
    .is_top(rk_top), .is_bot(rk_bot)
  );

  cand_pick u_pick (
    .clamp_hi(hi_q), .clamp_lo(lo_q), .leg(leg_q), .pick(cnt_q), .cand_idx(cand)
  );

  state_cost #(.REF_W(REF_W), .V_HI(V_HI), .V_LO(V_LO)) u_cost (
    .ref_a(ra_q), .ref_b(rb_q), .ref_c(rc_q), .bits(idx2bits(cand)), .cost(ccost)
  );

  always_comb begin
    ra_d = ra_q; rb_d = rb_q; rc_d = rc_q; leg_d = leg_q;
    hi_d = hi_q; lo_d = lo_q; busy_d = busy_q; cnt_d = cnt_q;
    best_d = best_q; bcost_d = bcost_q; st_d = st_q; done_d = 1'b0;
    accept = start && !busy_q;
    take   = (cnt_q == '0) || (ccost < bcost_q);
    last   = (hi_q || lo_q) ? (cnt_q == LAST_CLAMP) : (cnt_q == LAST_FULL);
    win    = take ? cand : best_q;
    if (accept) begin
      ra_d = ref_a; rb_d = ref_b; rc_d = ref_c; leg_d = aged_leg;
      hi_d = rk_top; lo_d = rk_bot; busy_d = 1'b1; cnt_d = '0;
    end else if (busy_q) begin
      if (take) begin
        best_d  = cand;
        bcost_d = ccost;
      end
      cnt_d = cnt_q + 1'b1;
      if (last) begin
        busy_d = 1'b0;
        st_d   = idx2bits(win);
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ra_q <= '0; rb_q <= '0; rc_q <= '0; leg_q <= '0;
      hi_q <= 1'b0; lo_q <= 1'b0; busy_q <= 1'b0; done_q <= 1'b0;
      cnt_q <= '0; best_q <= '0; bcost_q <= '0; st_q <= '0;
    end else begin
      ra_q <= ra_d; rb_q <= rb_d; rc_q <= rc_d; leg_q <= leg_d;
      hi_q <= hi_d; lo_q <= lo_d; busy_q <= busy_d; done_q <= done_d;
      cnt_q <= cnt_d; best_q <= best_d; bcost_q <= bcost_d; st_q <= st_d;
    end
  end

  assign sw_state = st_q;
  assign done     = done_q;

  // assertions
  logic aged_bit;
  always_comb begin
    case (leg_q)
      2'd0:    aged_bit = sw_state[2];
      2'd1:    aged_bit = sw_state[1];
      default: aged_bit = sw_state[0];
    endcase
  end

  p_clamp_hi_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (done && hi_q) |-> aged_bit);
  p_clamp_lo_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (done && lo_q) |-> !aged_bit);
  p_single_rank_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(hi_q && lo_q));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |=> !done);
  p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(done) |-> $past(busy_q));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    !done |-> $stable(sw_state));
  p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (busy_q && start && !last) |=> (busy_q && $stable(leg_q)));
endmodule

// File: tb/leg_relief_selector_tb.sv
module leg_relief_selector_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic signed [11:0] ref_a = '0, ref_b = '0, ref_c = '0;
  logic [1:0] aged_leg = '0;
  logic [2:0] sw_state;
  logic done;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  leg_relief_selector dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_a(ref_a), .ref_b(ref_b),
    .ref_c(ref_c), .aged_leg(aged_leg), .sw_state(sw_state), .done(done)
  );

  // references, aged leg, expected state, expected cycles, requirement tag
  localparam int TA[NV]  = '{ 800, -900, 100, -200, -100, 800, 500, 300, -300, -300, -300, 0, 0, 900, 50};
  localparam int TB[NV]  = '{-300,  200, 700,  900, -500, 600,-500,-700, -300, -300, -300, 0, 0,-900,-40};
  localparam int TC[NV]  = '{-500,  100,-600,  300, -800, 200, 100,-100, -300, -300, -300, 0, 0, 900, 30};
  localparam int TL[NV]  = '{   0,    0,   0,    1,    0,   2,   2,   1,    0,    2,    1, 0, 1,   3,  1};
  localparam int TS[NV]  = '{   4,    3,   6,    3,    4,   6,   5,   4,    4,    0,    0, 4, 0,   5,  5};
  localparam int TN[NV]  = '{   4,    4,   8,    4,    4,   4,   8,   4,    4,    4,    8, 4, 8,   8,  4};
  // rows: 0 R3, 1 R4, 2 R5, 3 R3, 4 R3, 5 R4, 6 R5, 7 R4, 8-10 R7, 11-12 R8, 13 R5, 14 R6
  localparam int TR[NV]  = '{   3,    4,   5,    3,    3,   4,   5,   4,    7,    7,    7, 8, 8,   5,  6};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // drive one sample; returns cycles to done and the state seen
  task automatic run(input int a, input int b, input int c, input int l,
                     output int ncyc, output int st);
    @(negedge clk);
    ref_a = 12'(a); ref_b = 12'(b); ref_c = 12'(c); aged_leg = 2'(l);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ncyc = 0;
    while (!done && ncyc < 20) begin
      @(negedge clk);
      ncyc++;
    end
    st = int'(sw_state);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      chk(1'b0, "watchdog", cyc, 5000);
      finish_run();
    end
  end

  initial begin
    int nc, st, st0;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 done in reset", int'(done), 0);
    chk(sw_state == 3'b000, "R1 state in reset", int'(sw_state), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(done == 1'b0, "R1 done after release", int'(done), 0);
    chk(sw_state == 3'b000, "R1 state after release", int'(sw_state), 0);

    // table walk: R2 encoding throughout, R6 cost, R9 latency
    for (int i = 0; i < NV; i++) begin
      run(TA[i], TB[i], TC[i], TL[i], nc, st);
      chk(st == TS[i], $sformatf("R%0d/R2 vec %0d state", TR[i], i), st, TS[i]);
      chk(nc == TN[i], $sformatf("R9 vec %0d cycles", i), nc, TN[i]);
      @(negedge clk);
      chk(done == 1'b0, $sformatf("R9 vec %0d pulse width", i), int'(done), 0);
      // R11: state held while idle
      repeat (3) @(negedge clk);
      chk(int'(sw_state) == TS[i], $sformatf("R11 vec %0d hold", i), int'(sw_state), TS[i]);
    end

    // R10: start during evaluation ignored
    @(negedge clk);
    ref_a = 12'(-100); ref_b = -12'sd500; ref_c = -12'sd800; aged_leg = 2'd0;
    start = 1'b1;
    @(negedge clk);
    ref_a = 12'sd100; ref_b = 12'sd700; ref_c = -12'sd600; aged_leg = 2'd3;
    nc = 0;
    @(negedge clk);
    nc = 1;
    start = 1'b0;
    while (!done && nc < 20) begin
      @(negedge clk);
      nc++;
    end
    chk(sw_state == 3'b100, "R10 result unchanged by late start", int'(sw_state), 4);
    chk(nc == 4, "R10 timing unchanged by late start", nc, 4);
    st0 = int'(sw_state);
    repeat (10) begin
      @(negedge clk);
      chk(done == 1'b0, "R10 no second result", int'(done), 0);
    end
    chk(int'(sw_state) == st0, "R11 hold after ignored start", int'(sw_state), st0);

    // R1: reset mid-run clears result
    run(900, -900, 900, 3, nc, st);
    rst_n = 1'b0;
    @(negedge clk);
    chk(sw_state == 3'b000, "R1 reset clears state", int'(sw_state), 0);
    chk(done == 1'b0, "R1 reset clears done", int'(done), 0);

    finish_run();
  end
endmodule